// File: doc/BRIEF.md
# Timer with Shared Prescaler

This block is an 8-bit up-counter paired with a watchdog tick counter. The two share one power-of-two prescaler. A control byte on a small register bus sets four things: the counter's clock source, the active edge of the external count pin, which of the two counters owns the prescaler, and the division code. The same code divides twice as finely for the counter as for the watchdog. Whichever counter does not own the prescaler advances once per source event.

The counter gives a one-cycle overflow pulse when it wraps. Software can read it and load it over the bus. The watchdog advances on a base tick input only while its enable bit is set. It gives a one-cycle timeout pulse when its tick counter wraps. A clear input restarts the watchdog. The integrating chip provides the instruction-cycle strobe, the watchdog base tick and the asynchronous count pin.

Top module: `tmr_shared_psc`

## Requirements
- R1: With the control source bit (bit 0) at 0 and the prescaler on the watchdog, the counter advances by one at each clock edge on which `cyc_tick` is high.
- R2: With the source bit at 1 and the edge bit (bit 1) at 0, the counter advances once per low-to-high change of `ext_pin`. The new value is readable after the third clock edge following the change. `cyc_tick` has no effect in this mode.
- R3: With the source bit at 1 and the edge bit at 1, only high-to-low changes of `ext_pin` advance the counter.
- R4: With the owner bit (bit 2) at 1, rate code r (bits 5:3) makes the counter advance once per 2^(r+1) source events. The watchdog then advances once per enabled base tick.
- R5: With the owner bit at 0, rate code r makes the watchdog advance once per 2^r enabled base ticks. The counter then advances on every source event.
- R6: When the counter steps from 0xFF to 0x00, `ovf_pulse` is high for exactly the following cycle.
- R7: A bus write to address 0 loads the counter and gives no increment in that cycle. It also clears the prescaler count when the counter owns the prescaler.
- R8: While the enable bit (address 2, bit 0) is 0, `wdt_base` leaves the watchdog state unchanged and no timeout occurs.
- R9: `wdt_timeout` is high for exactly one cycle when the 8-bit watchdog counter wraps to zero.
- R10: `wdt_clr` zeroes the watchdog counter. It also clears the prescaler count when the watchdog owns the prescaler.
- R11: After reset, all registers read 0: counter at address 0, control at address 1, watchdog enable at address 2. A control write takes effect at once and clears the prescaler count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_tick | input | 1 | Instruction-cycle strobe, internal count source |
| ext_pin | input | 1 | Asynchronous external count pin |
| wdt_base | input | 1 | Watchdog base tick strobe |
| wdt_clr | input | 1 | Watchdog restart |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 counter, 1 control, 2 watchdog enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| ovf_pulse | output | 1 | One-cycle counter wrap pulse |
| wdt_timeout | output | 1 | One-cycle watchdog wrap pulse |

## Verification
The counter is driven in five ways: steady and gapped instruction strobes, rising pin edges, falling pin edges, and instruction strobes while the pin source is selected. Together these tell apart a wrong source mux, a wrong edge polarity and a missing synchronizer delay. Prescaler ownership is tested from both sides at several codes. A run that stops one event short of the divide ratio, followed by one more event, separates the two ratio tables. A load or clear made mid-period shows whether the prescaler count was really cleared. A long run of base ticks with the watchdog disabled shows that the disabled watchdog kept no state.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int RATE_W = 3;

    typedef enum logic [1:0] {
        REG_COUNT = 2'd0,
        REG_CTRL  = 2'd1,
        REG_WDOG  = 2'd2,
        REG_NONE  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        OWN_WDOG  = 1'b0,
        OWN_TIMER = 1'b1
    } psc_owner_e;

    // Control byte layout: [5:3] rate, [2] owner, [1] falling edge, [0] pin source
    typedef struct packed {
        logic [RATE_W-1:0] rate;
        psc_owner_e        owner;
        logic              fall_edge;
        logic              src_pin;
    } tmr_ctrl_t;

    // Routing of the single prescaler between its two possible owners
    typedef struct packed {
        logic psc_in;
        logic tmr_step;
        logic wdt_step;
    } tmr_route_t;

    // Division exponent: the counter table sits one octave above the watchdog table
    function automatic logic [RATE_W:0] psc_shift(tmr_ctrl_t c);
        logic [RATE_W:0] base;
        base = {1'b0, c.rate};
        if (c.owner == OWN_TIMER)
            return base + {{RATE_W{1'b0}}, 1'b1};
        return base;
    endfunction

endpackage

// File: rtl/tmr_event_sel.sv
module tmr_event_sel #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cyc_tick,
    input  logic ext_pin,
    input  logic src_pin,
    input  logic fall_edge,
    output logic evt
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sh;
    logic            cur;
    logic            prv;
    logic            pin_evt;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[SH_W-2:0], ext_pin};
    end

    assign cur = sh[SYNC_STAGES-1];
    assign prv = sh[SYNC_STAGES];

    always_comb begin
        if (fall_edge) pin_evt = prv & ~cur;
        else           pin_evt = cur & ~prv;
        evt = src_pin ? pin_evt : cyc_tick;
    end

    // A synchronized edge yields a single event
    AST_PIN_EDGE_ONCE: assert property (@(posedge clk) disable iff (rst)
        pin_evt |=> !pin_evt); // R2

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PSC_W   = 8,
    parameter int SHIFT_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               evt_in,
    input  logic [SHIFT_W-1:0] shift,
    output logic               evt_out
);
    localparam int MASK_W = PSC_W + 1;

    logic [PSC_W-1:0]  psc_cnt;
    logic [MASK_W-1:0] mask;
    logic              term;

    always_comb begin
        mask    = (MASK_W'(1) << shift) - MASK_W'(1);
        term    = (psc_cnt == mask[PSC_W-1:0]);
        evt_out = evt_in & term & ~clr;
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            psc_cnt <= '0;
        else if (evt_in) begin
            if (term) psc_cnt <= '0;
            else      psc_cnt <= psc_cnt + PSC_W'(1);
        end
    end

    AST_PSC_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, psc_cnt} <= mask)); // R4

    AST_PSC_RESTART: assert property (@(posedge clk) disable iff (rst)
        evt_out |=> (psc_cnt == '0)); // R5

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             step,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (wr) begin
            cnt <= wdata;
            ovf <= 1'b0;
        end else begin
            ovf <= step && (cnt == TOP);
            if (step) cnt <= cnt + CNT_W'(1);
        end
    end

    AST_STEP_INC: assert property (@(posedge clk) disable iff (rst)
        (step && !wr) |=> (cnt == CNT_W'($past(cnt) + CNT_W'(1)))); // R1

    AST_WR_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr |=> (cnt == $past(wdata))); // R7

    AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        ovf |-> (cnt == '0)); // R6

    AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ovf |=> !ovf); // R6

endmodule

// File: rtl/tmr_wdog.sv
module tmr_wdog #(
    parameter int WDT_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic clr,
    input  logic step,
    output logic timeout
);
    localparam logic [WDT_W-1:0] TOP = {WDT_W{1'b1}};

    logic [WDT_W-1:0] wcnt;
    logic             adv;

    assign adv = step & en;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wcnt    <= '0;
            timeout <= 1'b0;
        end else begin
            timeout <= adv && (wcnt == TOP);
            if (adv) wcnt <= wcnt + WDT_W'(1);
        end
    end

    AST_WDT_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
        (!en && !clr) |=> $stable(wcnt)); // R8

    AST_TIMEOUT_PULSE: assert property (@(posedge clk) disable iff (rst)
        timeout |=> !timeout); // R9

    AST_CLR_RESTART: assert property (@(posedge clk) disable iff (rst)
        clr |=> (wcnt == '0 && !timeout)); // R10

endmodule

// File: rtl/tmr_shared_psc.sv
module tmr_shared_psc
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int WDT_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int BUS_AW      = 2,
    parameter int BUS_DW      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_tick,
    input  logic              ext_pin,
    input  logic              wdt_base,
    input  logic              wdt_clr,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              ovf_pulse,
    output logic              wdt_timeout
);
    localparam int CTRL_W  = $bits(tmr_ctrl_t);
    localparam int SHIFT_W = RATE_W + 1;
    localparam int PSC_W   = 1 << RATE_W;

    tmr_ctrl_t        ctrl;
    logic             wdt_en;
    reg_sel_e         sel;
    logic             cnt_wr, ctl_wr, wdc_wr;
    logic             tmr_evt;
    logic             base_ok;
    logic             psc_out;
    logic             psc_clr;
    logic             own_t;
    tmr_route_t       route;
    logic [CNT_W-1:0] cnt;

    assign sel    = reg_sel_e'(bus_addr);
    assign cnt_wr = bus_wr && (sel == REG_COUNT);
    assign ctl_wr = bus_wr && (sel == REG_CTRL);
    assign wdc_wr = bus_wr && (sel == REG_WDOG);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            wdt_en <= 1'b0;
        end else begin
            if (ctl_wr) ctrl   <= tmr_ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (wdc_wr) wdt_en <= bus_wdata[0];
        end
    end

    always_comb begin
        case (sel)
            REG_COUNT: bus_rdata = BUS_DW'(cnt);
            REG_CTRL:  bus_rdata = BUS_DW'(ctrl);
            REG_WDOG:  bus_rdata = BUS_DW'(wdt_en);
            default:   bus_rdata = '0;
        endcase
    end

    // Prescaler steering
    assign own_t   = (ctrl.owner == OWN_TIMER);
    assign base_ok = wdt_base & wdt_en;

    always_comb begin
        route.psc_in   = own_t ? tmr_evt : base_ok;
        route.tmr_step = own_t ? psc_out : tmr_evt;
        route.wdt_step = own_t ? base_ok : psc_out;
        psc_clr        = ctl_wr | (own_t ? cnt_wr : wdt_clr);
    end

    tmr_event_sel #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_evt (
        .clk      (clk),
        .rst      (rst),
        .cyc_tick (cyc_tick),
        .ext_pin  (ext_pin),
        .src_pin  (ctrl.src_pin),
        .fall_edge(ctrl.fall_edge),
        .evt      (tmr_evt)
    );

    tmr_prescaler #(
        .PSC_W  (PSC_W),
        .SHIFT_W(SHIFT_W)
    ) u_psc (
        .clk    (clk),
        .rst    (rst),
        .clr    (psc_clr),
        .evt_in (route.psc_in),
        .shift  (psc_shift(ctrl)),
        .evt_out(psc_out)
    );

    tmr_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .wr   (cnt_wr),
        .wdata(bus_wdata[CNT_W-1:0]),
        .step (route.tmr_step),
        .cnt  (cnt),
        .ovf  (ovf_pulse)
    );

    tmr_wdog #(
        .WDT_W(WDT_W)
    ) u_wdt (
        .clk    (clk),
        .rst    (rst),
        .en     (wdt_en),
        .clr    (wdt_clr),
        .step   (route.wdt_step),
        .timeout(wdt_timeout)
    );

    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (rst)
        ctl_wr |=> (ctrl == $past(bus_wdata[CTRL_W-1:0]))); // R11

    AST_NO_STEP_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        (cnt_wr && !ovf_pulse) |=> !ovf_pulse); // R7

endmodule

// File: tb/tb_tmr_shared_psc.sv
module tb_tmr_shared_psc;

    logic       clk = 1'b0;
    logic       rst;
    logic       cyc_tick, ext_pin, wdt_base, wdt_clr, bus_wr;
    logic [1:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       ovf_pulse, wdt_timeout;

    always #5 clk = ~clk;

    tmr_shared_psc dut (
        .clk(clk), .rst(rst), .cyc_tick(cyc_tick), .ext_pin(ext_pin),
        .wdt_base(wdt_base), .wdt_clr(wdt_clr), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ovf_pulse(ovf_pulse), .wdt_timeout(wdt_timeout)
    );

    // kind: 0 read data, 1 overflow pulse, 2 timeout pulse
    typedef struct {
        int         kind;
        logic [7:0] exp;
        string      req;
    } item_t;

    item_t q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 0;

    // Monitor: compares queued expectations midway between edges
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t      it;
            logic [7:0] act;
            it = q.pop_front();
            case (it.kind)
                0:       act = bus_rdata;
                1:       act = {7'd0, ovf_pulse};
                default: act = {7'd0, wdt_timeout};
            endcase
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s kind=%0d actual=0x%02h expected=0x%02h t=%0t",
                         it.req, it.kind, act, it.exp, $time);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic push(int kind, logic [7:0] exp, string req);
        item_t it;
        it.kind = kind; it.exp = exp; it.req = req;
        q.push_back(it);
    endtask

    task automatic bus_write(logic [1:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic expect_reg(logic [1:0] a, logic [7:0] exp, string req);
        bus_addr = a;
        push(0, exp, req);
        tick();
    endtask

    task automatic cyc_run(int n);
        for (int i = 0; i < n; i++) begin
            cyc_tick = 1'b1;
            tick();
        end
        cyc_tick = 1'b0;
    endtask

    task automatic pin_hold(logic v, int n);
        ext_pin = v;
        for (int i = 0; i < n; i++) tick();
    endtask

    // n base ticks; timeout expected only after the last one when fires is set
    task automatic wdt_run(int n, bit fires, string req);
        for (int i = 1; i <= n; i++) begin
            wdt_base = 1'b1;
            tick();
            push(2, {7'd0, (fires && i == n)}, req);
        end
        wdt_base = 1'b0;
        tick();
        push(2, 8'h00, req);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: all requirements, actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cyc_tick = 0; ext_pin = 0; wdt_base = 0; wdt_clr = 0;
        bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R11 reset state
        push(1, 8'h00, "R11 ovf after reset");
        push(2, 8'h00, "R11 timeout after reset");
        expect_reg(2'd0, 8'h00, "R11 counter reset");
        expect_reg(2'd1, 8'h00, "R11 control reset");
        expect_reg(2'd2, 8'h00, "R11 wdog enable reset");

        // R1 internal source, prescaler on watchdog
        cyc_run(5);
        expect_reg(2'd0, 8'h05, "R1 steady strobes");
        for (int i = 0; i < 3; i++) begin
            cyc_tick = 1'b1; tick();
            cyc_tick = 1'b0; tick();
        end
        expect_reg(2'd0, 8'h08, "R1 gapped strobes");

        // R7 load with strobe active: no increment
        cyc_tick = 1'b1;
        bus_write(2'd0, 8'hFD);
        cyc_tick = 1'b0;
        expect_reg(2'd0, 8'hFD, "R7 load wins over step");

        // R6 wrap pulse
        cyc_run(3);
        push(1, 8'h01, "R6 pulse on wrap");
        tick();
        push(1, 8'h00, "R6 pulse one cycle");
        expect_reg(2'd0, 8'h00, "R6 counter wrapped");

        // R4 prescaler on counter, 1:2
        bus_write(2'd1, 8'h04);
        expect_reg(2'd1, 8'h04, "R11 control readback");
        bus_write(2'd0, 8'h00);
        cyc_run(5);
        expect_reg(2'd0, 8'h02, "R4 1:2 after five");
        cyc_run(1);
        expect_reg(2'd0, 8'h03, "R4 1:2 after six");

        // R4 1:8, then R7 clear of prescaler by load
        bus_write(2'd1, 8'h14);
        bus_write(2'd0, 8'h00);
        cyc_run(20);
        expect_reg(2'd0, 8'h02, "R4 1:8 after twenty");
        bus_write(2'd0, 8'h10);
        cyc_run(7);
        expect_reg(2'd0, 8'h10, "R7 prescaler cleared by load");
        cyc_run(1);
        expect_reg(2'd0, 8'h11, "R7 full period after load");

        // R4 1:256
        bus_write(2'd1, 8'h3C);
        bus_write(2'd0, 8'h00);
        cyc_run(255);
        expect_reg(2'd0, 8'h00, "R4 1:256 one short");
        cyc_run(1);
        expect_reg(2'd0, 8'h01, "R4 1:256 complete");

        // R2 rising edges of the pin
        bus_write(2'd1, 8'h01);
        bus_write(2'd0, 8'h00);
        ext_pin = 1'b1;
        tick(); tick();
        expect_reg(2'd0, 8'h00, "R2 not yet through synchronizer");
        expect_reg(2'd0, 8'h01, "R2 third edge latency");
        pin_hold(1'b0, 4);
        pin_hold(1'b1, 4);
        expect_reg(2'd0, 8'h02, "R2 second rising edge");
        pin_hold(1'b0, 4);
        expect_reg(2'd0, 8'h02, "R2 falling edge ignored");
        cyc_run(3);
        expect_reg(2'd0, 8'h02, "R2 strobe ignored with pin source");

        // R3 falling edges of the pin
        bus_write(2'd1, 8'h03);
        bus_write(2'd0, 8'h00);
        pin_hold(1'b1, 4);
        expect_reg(2'd0, 8'h00, "R3 rising edge ignored");
        pin_hold(1'b0, 4);
        expect_reg(2'd0, 8'h01, "R3 falling edge counted");

        // R8 disabled watchdog keeps no state (prescaler on watchdog, 1:1)
        bus_write(2'd1, 8'h00);
        wdt_run(300, 1'b0, "R8 disabled no timeout");
        bus_write(2'd2, 8'h01);
        expect_reg(2'd2, 8'h01, "R11 enable readback");
        wdt_run(256, 1'b1, "R9 timeout after 256 ticks");

        // R5 watchdog 1:4
        bus_write(2'd1, 8'h10);
        wdt_run(1024, 1'b1, "R5 watchdog 1:4");

        // R10 clear mid-period restarts counter and prescaler
        wdt_run(502, 1'b0, "R10 partial run");
        wdt_clr = 1'b1; tick(); wdt_clr = 1'b0;
        wdt_run(1024, 1'b1, "R10 full period after clear");

        // R4 watchdog at 1:1 while prescaler is on the counter
        bus_write(2'd1, 8'h04);
        wdt_clr = 1'b1; tick(); wdt_clr = 1'b0;
        wdt_run(256, 1'b1, "R4 watchdog direct with counter owning");

        tick(); tick();
        done = 1;
        summary();
        $finish;
    end

endmodule